// File: doc/BRIEF.md
# Check-Node Min-Sum Unit

This unit forms the outgoing check-to-variable messages of one parity check with up to eight edges, using the plain min-sum rule with no scaling and no offset. Each edge arrives on its own 6-bit two's-complement port, and an 8-bit connection mask says which edges belong to the check row. Every connected edge gets back two things. Its sign is the parity of the signs on the other connected edges. Its magnitude is the smallest magnitude among those other edges.

Internally the unit converts each edge to sign and magnitude without using signed comparison. It then finds the smallest and second-smallest magnitudes and the position of the smallest. Each output takes either the minimum or, at the position that owns the minimum, the second minimum. The datapath is combinational. The parameter `REGISTER_OUT` selects an output register that loads when `in_valid` is high and otherwise holds. The surrounding decoder owns message storage and iteration control.

Top module: `cn_minsum_unit`

## Requirements
- R1: For every connected edge i, the magnitude of output i equals the smallest clamped magnitude among the other connected edges.
- R2: The sign of output i equals the XOR of the sign bits (bit 5) of the other connected edges. A negative output is the two's-complement negation of its magnitude.
- R3: The input value -32 (6'b100000) counts as magnitude 31. No output ever carries the value -32.
- R4: Mask bit i applies to port v2c_i, and a mask bit of 0 makes that edge behave as +31. Such an edge adds nothing to any sign. A connected edge whose only peers are unconnected therefore outputs +31.
- R5: The output of an unconnected edge is 0.
- R6: When two or more connected edges share the smallest magnitude, every connected output has exactly that magnitude, including the outputs of the tied edges.
- R7: With REGISTER_OUT=1, the outputs show the result for the inputs sampled at a rising edge where in_valid is high, starting right after that edge. out_valid is in_valid delayed by one clock.
- R8: With REGISTER_OUT=1, the outputs keep their previous values across any clock edge where in_valid is low.
- R9: While rst_n is low, every output is 0 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input set valid; load enable for the output register |
| conn_mask | input | 8 | Bit i set means edge i is part of the check row |
| v2c_0 | input | 6 | Incoming message, edge 0 |
| v2c_1 | input | 6 | Incoming message, edge 1 |
| v2c_2 | input | 6 | Incoming message, edge 2 |
| v2c_3 | input | 6 | Incoming message, edge 3 |
| v2c_4 | input | 6 | Incoming message, edge 4 |
| v2c_5 | input | 6 | Incoming message, edge 5 |
| v2c_6 | input | 6 | Incoming message, edge 6 |
| v2c_7 | input | 6 | Incoming message, edge 7 |
| out_valid | output | 1 | Outputs hold a fresh result |
| c2v_0 | output | 6 | Outgoing message, edge 0 |
| c2v_1 | output | 6 | Outgoing message, edge 1 |
| c2v_2 | output | 6 | Outgoing message, edge 2 |
| c2v_3 | output | 6 | Outgoing message, edge 3 |
| c2v_4 | output | 6 | Outgoing message, edge 4 |
| c2v_5 | output | 6 | Outgoing message, edge 5 |
| c2v_6 | output | 6 | Outgoing message, edge 6 |
| c2v_7 | output | 6 | Outgoing message, edge 7 |

## Verification
The bench sweeps every 64 values on two edges and every one of the 256 masks, and it targets the corner cases below.
- **Input -32.** A magnitude computation that wraps would turn -32 into magnitude 0 and pull every other output to zero.
- **Unconnected lanes.** If an unconnected lane read as zero, it would zero the outputs. If it still counted in the sign, half the outputs would have the wrong sign.
- **Lone connected edge.** This shows whether the +31 default reaches the output.
- **Tied minima.** These show whether the owner of the minimum wrongly reports a larger second minimum.
- **Register enable.** Inputs that change while in_valid is low must leave the outputs untouched.

// File: rtl/cnmin_pkg.sv
package cnmin_pkg;
  // Fixed check degree: one port per edge.
  localparam int unsigned DEG   = 8;
  localparam int unsigned IDX_W = $clog2(DEG);
endpackage

// File: rtl/cnmin_edge_prep.sv
module cnmin_edge_prep #(
  parameter int unsigned MSG_W = 6,
  localparam int unsigned MAG_W = MSG_W - 1
) (
  input  logic [MSG_W-1:0] msg,
  input  logic             conn,
  output logic             sgn,
  output logic [MAG_W-1:0] mag
);
  localparam logic [MAG_W-1:0] MAG_MAX = '1;

  logic [MSG_W-1:0] negated;

  always_comb begin
    negated = ~msg + MSG_W'(1);
    if (!conn) begin
      sgn = 1'b0;
      mag = MAG_MAX;
    end else if (!msg[MSG_W-1]) begin
      sgn = 1'b0;
      mag = msg[MAG_W-1:0];
    end else if (negated[MSG_W-1]) begin
      // only the most negative code negates back to negative: clamp
      sgn = 1'b1;
      mag = MAG_MAX;
    end else begin
      sgn = 1'b1;
      mag = negated[MAG_W-1:0];
    end
  end
endmodule

// File: rtl/cnmin_min_find.sv
module cnmin_min_find #(
  parameter int unsigned MAG_W = 5,
  parameter int unsigned DEG   = 8,
  localparam int unsigned IDX_W = $clog2(DEG)
) (
  input  logic [DEG*MAG_W-1:0] mags,
  output logic [MAG_W-1:0]     min1,
  output logic [MAG_W-1:0]     min2,
  output logic [IDX_W-1:0]     min_idx
);
  logic [MAG_W-1:0] cur;

  // Strict less-than keeps the lowest index on ties; an equal later value
  // lands in the second slot.
  always_comb begin
    min1    = '1;
    min2    = '1;
    min_idx = '0;
    cur     = '0;
    for (int i = 0; i < int'(DEG); i++) begin
      cur = mags[i*MAG_W +: MAG_W];
      if (cur < min1) begin
        min2    = min1;
        min1    = cur;
        min_idx = IDX_W'(i);
      end else if (cur < min2) begin
        min2 = cur;
      end
    end
  end
endmodule

// File: rtl/cnmin_out_form.sv
module cnmin_out_form #(
  parameter int unsigned MSG_W = 6,
  localparam int unsigned MAG_W = MSG_W - 1
) (
  input  logic             parity_all,
  input  logic             sgn_self,
  input  logic             conn,
  input  logic             owns_min,
  input  logic [MAG_W-1:0] min1,
  input  logic [MAG_W-1:0] min2,
  output logic [MSG_W-1:0] msg_out
);
  logic             sgn_out;
  logic [MAG_W-1:0] mag_out;
  logic [MSG_W-1:0] pos_val;

  always_comb begin
    sgn_out = parity_all ^ sgn_self;
    mag_out = owns_min ? min2 : min1;
    pos_val = {1'b0, mag_out};
    if (!conn)        msg_out = '0;
    else if (sgn_out) msg_out = ~pos_val + MSG_W'(1);
    else              msg_out = pos_val;
  end
endmodule

// File: rtl/cn_minsum_unit.sv
module cn_minsum_unit
  import cnmin_pkg::*;
#(
  parameter int unsigned MSG_W        = 6,
  parameter bit          REGISTER_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DEG-1:0]   conn_mask,
  input  logic [MSG_W-1:0] v2c_0,
  input  logic [MSG_W-1:0] v2c_1,
  input  logic [MSG_W-1:0] v2c_2,
  input  logic [MSG_W-1:0] v2c_3,
  input  logic [MSG_W-1:0] v2c_4,
  input  logic [MSG_W-1:0] v2c_5,
  input  logic [MSG_W-1:0] v2c_6,
  input  logic [MSG_W-1:0] v2c_7,
  output logic             out_valid,
  output logic [MSG_W-1:0] c2v_0,
  output logic [MSG_W-1:0] c2v_1,
  output logic [MSG_W-1:0] c2v_2,
  output logic [MSG_W-1:0] c2v_3,
  output logic [MSG_W-1:0] c2v_4,
  output logic [MSG_W-1:0] c2v_5,
  output logic [MSG_W-1:0] c2v_6,
  output logic [MSG_W-1:0] c2v_7
);
  localparam int unsigned MAG_W = MSG_W - 1;
  localparam logic [MSG_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  logic [MSG_W-1:0]     v2c_arr [DEG];
  logic [MSG_W-1:0]     comb_out [DEG];
  logic [MSG_W-1:0]     out_arr [DEG];
  logic [DEG-1:0]       sgn_vec;
  logic [DEG*MAG_W-1:0] mag_flat;
  logic [MAG_W-1:0]     min1;
  logic [MAG_W-1:0]     min2;
  logic [IDX_W-1:0]     min_idx;
  logic                 parity_all;

  assign v2c_arr[0] = v2c_0;
  assign v2c_arr[1] = v2c_1;
  assign v2c_arr[2] = v2c_2;
  assign v2c_arr[3] = v2c_3;
  assign v2c_arr[4] = v2c_4;
  assign v2c_arr[5] = v2c_5;
  assign v2c_arr[6] = v2c_6;
  assign v2c_arr[7] = v2c_7;

  for (genvar k = 0; k < int'(DEG); k++) begin : g_prep
    cnmin_edge_prep #(.MSG_W(MSG_W)) u_prep (
      .msg  (v2c_arr[k]),
      .conn (conn_mask[k]),
      .sgn  (sgn_vec[k]),
      .mag  (mag_flat[k*MAG_W +: MAG_W])
    );
  end

  cnmin_min_find #(.MAG_W(MAG_W), .DEG(DEG)) u_min (
    .mags    (mag_flat),
    .min1    (min1),
    .min2    (min2),
    .min_idx (min_idx)
  );

  assign parity_all = ^sgn_vec;

  for (genvar k = 0; k < int'(DEG); k++) begin : g_form
    cnmin_out_form #(.MSG_W(MSG_W)) u_form (
      .parity_all (parity_all),
      .sgn_self   (sgn_vec[k]),
      .conn       (conn_mask[k]),
      .owns_min   (min_idx == IDX_W'(k)),
      .min1       (min1),
      .min2       (min2),
      .msg_out    (comb_out[k])
    );
  end

  if (REGISTER_OUT) begin : g_reg
    logic [MSG_W-1:0] out_q   [DEG];
    logic [MSG_W-1:0] out_nxt [DEG];
    logic             vld_q;

    always_comb begin
      for (int k = 0; k < int'(DEG); k++) begin
        out_nxt[k] = in_valid ? comb_out[k] : out_q[k];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        for (int k = 0; k < int'(DEG); k++) out_q[k] <= '0;
      end else begin
        vld_q <= in_valid;
        for (int k = 0; k < int'(DEG); k++) out_q[k] <= out_nxt[k];
      end
    end

    assign out_valid = vld_q;
    for (genvar k = 0; k < int'(DEG); k++) begin : g_drv
      assign out_arr[k] = out_q[k];
    end

    // R7
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    // R7
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

    for (genvar k = 0; k < int'(DEG); k++) begin : g_reg_chk
      // R8
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_q[k]));
      // R5
      unconn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !conn_mask[k]) |=> (out_q[k] == '0));
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    for (genvar k = 0; k < int'(DEG); k++) begin : g_drv
      assign out_arr[k] = comb_out[k];
    end
  end

  assign c2v_0 = out_arr[0];
  assign c2v_1 = out_arr[1];
  assign c2v_2 = out_arr[2];
  assign c2v_3 = out_arr[3];
  assign c2v_4 = out_arr[4];
  assign c2v_5 = out_arr[5];
  assign c2v_6 = out_arr[6];
  assign c2v_7 = out_arr[7];

  // Tie count on the minimum, used only by the checks below.
  int unsigned tie_cnt;
  always_comb begin
    tie_cnt = 0;
    for (int k = 0; k < int'(DEG); k++) begin
      if (conn_mask[k] && (mag_flat[k*MAG_W +: MAG_W] == min1)) tie_cnt++;
    end
  end

  // R1
  min_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    min1 <= min2);
  // R1
  min_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|conn_mask) |-> (mag_flat[min_idx*MAG_W +: MAG_W] == min1));
  // R6
  tie_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tie_cnt >= 2) |-> (min2 == min1));

  for (genvar k = 0; k < int'(DEG); k++) begin : g_out_chk
    // R3
    no_most_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_arr[k] != MOST_NEG);
  end
endmodule

// File: tb/sim_cn_minsum_unit.sv
module sim_cn_minsum_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] conn_mask;
  logic [5:0] tv [8];
  logic [5:0] got [8];
  logic       out_valid;
  logic [5:0] c0, c1, c2, c3, c4, c5, c6, c7;

  int checks   = 0;
  int failures = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  cn_minsum_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .conn_mask(conn_mask),
    .v2c_0(tv[0]), .v2c_1(tv[1]), .v2c_2(tv[2]), .v2c_3(tv[3]),
    .v2c_4(tv[4]), .v2c_5(tv[5]), .v2c_6(tv[6]), .v2c_7(tv[7]),
    .out_valid(out_valid),
    .c2v_0(c0), .c2v_1(c1), .c2v_2(c2), .c2v_3(c3),
    .c2v_4(c4), .c2v_5(c5), .c2v_6(c6), .c2v_7(c7)
  );

  assign got[0] = c0; assign got[1] = c1; assign got[2] = c2; assign got[3] = c3;
  assign got[4] = c4; assign got[5] = c5; assign got[6] = c6; assign got[7] = c7;

  function automatic int mag_of(logic [5:0] v);
    int s;
    s = $signed(v);
    if (s < 0) s = -s;
    if (s > 31) s = 31;
    return s;
  endfunction

  function automatic logic [5:0] expect_edge(int i);
    int m;
    bit neg;
    int r;
    if (!conn_mask[i]) return 6'd0;
    m = 31;
    neg = 1'b0;
    for (int j = 0; j < 8; j++) begin
      if (j != i && conn_mask[j]) begin
        if (mag_of(tv[j]) < m) m = mag_of(tv[j]);
        neg = neg ^ tv[j][5];
      end
    end
    r = neg ? -m : m;
    return 6'(r);
  endfunction

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d (mask=%b)", tag, $signed(act), $signed(exp), conn_mask);
    end
  endtask

  task automatic apply_and_check(string tag);
    logic [5:0] e [8];
    @(negedge clk);
    in_valid = 1'b1;
    for (int i = 0; i < 8; i++) e[i] = expect_edge(i);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (!conn_mask[i]) check("R5", got[i], e[i]);
      else               check(tag, got[i], e[i]);
    end
    check("R7", {5'd0, out_valid}, 6'd1);
  endtask

  function automatic logic [5:0] rnd6();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[5:0];
  endfunction

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [5:0] held [8];
    rst_n = 1'b0;
    in_valid = 1'b0;
    conn_mask = 8'hFF;
    for (int i = 0; i < 8; i++) tv[i] = 6'd3;
    repeat (3) @(negedge clk);
    // R9: reset state
    for (int i = 0; i < 8; i++) check("R9", got[i], 6'd0);
    check("R9", {5'd0, out_valid}, 6'd0);
    rst_n = 1'b1;

    // R1 R2 R3: full sweep of edge 0, then edge 3
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 64; v++) begin
        tv[0] = 6'd5;  tv[1] = 6'h3D; tv[2] = 6'd12; tv[3] = 6'd7;
        tv[4] = 6'h2C; tv[5] = 6'd9;  tv[6] = 6'd15; tv[7] = 6'h31;
        conn_mask = 8'hFF;
        tv[p == 0 ? 0 : 3] = 6'(v);
        apply_and_check(v == 32 ? "R3" : "R1/R2");
      end
    end

    // R4 R5: every mask with pseudo-random messages
    for (int r = 0; r < 4; r++) begin
      for (int m = 0; m < 256; m++) begin
        conn_mask = 8'(m);
        for (int i = 0; i < 8; i++) tv[i] = rnd6();
        apply_and_check("R4");
      end
    end

    // R4: lone connected edge sees +31
    for (int k = 0; k < 8; k++) begin
      conn_mask = 8'(1 << k);
      for (int i = 0; i < 8; i++) tv[i] = 6'h20;
      apply_and_check("R4");
      check("R4", got[k], 6'd31);
    end

    // R3: several -32 inputs alongside +31
    conn_mask = 8'hFF;
    for (int i = 0; i < 8; i++) tv[i] = (i % 2 == 0) ? 6'h20 : 6'd31;
    apply_and_check("R3");

    // R6: ties on the minimum magnitude, mixed signs
    for (int t = 0; t < 32; t++) begin
      conn_mask = 8'hFF;
      for (int i = 0; i < 8; i++) tv[i] = 6'd20;
      tv[t % 8] = 6'(t % 4);
      tv[(t + 3) % 8] = 6'(-(t % 4));
      apply_and_check("R6");
      for (int i = 0; i < 8; i++) check("R6", 6'(mag_of(got[i])), 6'(t % 4));
    end

    // R8: new inputs while in_valid is low leave outputs alone
    conn_mask = 8'hFF;
    for (int i = 0; i < 8; i++) tv[i] = 6'(i + 4);
    apply_and_check("R1/R2");
    for (int i = 0; i < 8; i++) held[i] = got[i];
    in_valid = 1'b0;
    conn_mask = 8'h0F;
    for (int i = 0; i < 8; i++) tv[i] = 6'h3F;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) check("R8", got[i], held[i]);
    check("R7", {5'd0, out_valid}, 6'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule